// File: doc/BRIEF.md
# Scan Return Capture Buffer

This block collects the serial bits returning from a scan chain and turns them into bytes that a host reads in parallel. Two byte registers work as a two-entry queue. One of them takes incoming bits while the other holds a finished byte for the host. A byte ends either at an eight-bit boundary tick from the scan clock logic or at the terminal count of a scan length counter. The second case covers scan lengths that are not a multiple of eight.

Each new bit enters a register at its top and pushes the earlier bits toward bit 0. A short byte therefore keeps its meaningful bits in the upper positions, with zeros below them.

In compactor mode the same input stream is folded into a 16-bit signature instead of being queued. The host seeds the signature through byte writes.

Top module: `scan_capture_buffer`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rd_data` is 0 and `sig_value` is 0.
- R2: A bit is captured into the queue on a rising clock edge only when `cap_en` and `sck_en` are both 1, `sig_mode` is 0 and `full` is 0. In every other cycle the queue state is unchanged.
- R3: Each captured bit enters the active register at bit 7, and the earlier bits move one place toward bit 0. After eight captures, the first bit captured sits in bit 0.
- R4: A capture with `bit8_tick` high closes the active byte. The byte becomes readable from the next cycle, and later captures go to the other register.
- R5: A capture with both `len_en` and `len_tc` high also closes the byte. For a short byte, the captured bits sit in the upper positions and the lower bits read 0. For example, captures 1,1,0,1,0 give 8'h58. `len_tc` with `len_en` low closes nothing.
- R6: The queue holds two closed bytes. `full` is 1 while both are held, and captures are then ignored.
- R7: `rd_data` shows the oldest closed byte, or 0 while `empty` is 1. A read request removes that byte only when the queue is not empty and `sig_mode` is 0. Otherwise the request is ignored.
- R8: A write with `sig_mode` high shifts `wr_data` into the low byte of the signature, moving the old low byte up, so two writes of 8'h12 then 8'h34 give 16'h1234. A write with `sig_mode` low leaves the signature unchanged.
- R9: In compactor mode, each cycle with `cap_en` and `sck_en` high and no write updates the signature as follows. It forms f = `sig_value`[15] XOR `tdi_bit`, shifts the signature left by one, then XORs it with 16'h1021 when f is 1. From zero, a 1 bit gives 16'h1021. The queue is frozen in compactor mode.
- R10: Closed bytes are read out in the order they were closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tdi_bit | input | 1 | Serial bit returning from the scan chain |
| sck_en | input | 1 | Scan clock enable for this cycle |
| cap_en | input | 1 | Input capture enable mode bit |
| sig_mode | input | 1 | Selects signature compactor mode |
| bit8_tick | input | 1 | Eight bits have been captured in this cycle |
| len_en | input | 1 | Length counter enable |
| len_tc | input | 1 | Length counter at terminal count |
| rd_req | input | 1 | Byte read request |
| rd_data | output | 8 | Oldest closed byte |
| wr_req | input | 1 | Signature seed write request |
| wr_data | input | 8 | Signature seed byte |
| full | output | 1 | Both byte registers hold closed bytes |
| empty | output | 1 | No closed byte is held |
| sig_value | output | 16 | Current signature |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit signature and feedback constant 16'h1021. At these values the bit placement of a short byte, the two-entry fill limit and the signature arithmetic can all be stated as exact byte and word values. A behavioural queue-and-integer model is compared with the outputs on every cycle. Directed passes cover the corner cases: a close on the same cycle as a read, ticks while full, mode switches with a partial byte pending, and terminal counts with the length enable low. A long random pass then mixes all inputs.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned SIG_W_DEF  = 16;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic shift;
    logic bit_in;
    logic close;
  } cap_req_t;
endpackage

// File: rtl/scb_rst_sync.sv
module scb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/scb_byte_fifo.sv
module scb_byte_fifo
  import scb_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cap_req_t          req,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int unsigned SLOTS = 2;

  logic [BYTE_W-1:0] slot_q [SLOTS];
  logic [BYTE_W-1:0] slot_d [SLOTS];
  logic [SLOTS-1:0]  valid_q, valid_d;
  reg_sel_e          wsel_q, wsel_d, rsel_q, rsel_d;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_comb begin
      slot_d[g]  = slot_q[g];
      valid_d[g] = valid_q[g];
      if (req.shift && (wsel_q == reg_sel_e'(g))) begin
        slot_d[g] = {req.bit_in, slot_q[g][BYTE_W-1:1]};
        if (req.close) valid_d[g] = 1'b1;
      end
      if (pop && (rsel_q == reg_sel_e'(g))) begin
        slot_d[g]  = '0;
        valid_d[g] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else begin
        slot_q[g]  <= slot_d[g];
        valid_q[g] <= valid_d[g];
      end
    end
  end

  always_comb begin
    wsel_d = wsel_q;
    rsel_d = rsel_q;
    if (req.shift && req.close) wsel_d = reg_sel_e'(~wsel_q);
    if (pop)                    rsel_d = reg_sel_e'(~rsel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= SEL_A;
      rsel_q <= SEL_A;
    end else begin
      wsel_q <= wsel_d;
      rsel_q <= rsel_d;
    end
  end

  assign full  = &valid_q;
  assign empty = ~|valid_q;
  assign head  = empty ? '0 : ((rsel_q == SEL_B) ? slot_q[1] : slot_q[0]);

  // R6: with both bytes held and nothing popped, stored data stays put
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> ($stable(slot_q[0]) && $stable(slot_q[1])));
  // R6: the queue cannot be full and empty at once
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R7: the controller never pops an empty queue
  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4: a closing capture leaves a readable byte
  a_r4_close_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (req.shift && req.close) |=> !empty);
endmodule

// File: rtl/scb_sig_compactor.sv
module scb_sig_compactor
  import scb_pkg::*;
#(
  parameter int unsigned    BYTE_W   = BYTE_W_DEF,
  parameter int unsigned    SIG_W    = SIG_W_DEF,
  parameter logic [SIG_W-1:0] SIG_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_we,
  input  logic [BYTE_W-1:0] seed_byte,
  input  logic              step,
  input  logic              bit_in,
  output logic [SIG_W-1:0]  sig_q
);
  localparam int unsigned KEEP_W = SIG_W - BYTE_W;

  logic [SIG_W-1:0] sig_d;
  logic             fb;

  always_comb begin
    sig_d = sig_q;
    fb    = sig_q[SIG_W-1] ^ bit_in;
    if (seed_we) begin
      sig_d = {sig_q[KEEP_W-1:0], seed_byte};
    end else if (step) begin
      sig_d = {sig_q[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  // R8: signature moves only on a write or a compaction step
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && !step) |=> $stable(sig_q));
  // R9: a zero signature stays zero when zero bits are folded in
  a_r9_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seed_we && (sig_q == '0) && !bit_in) |=> (sig_q == '0));
endmodule

// File: rtl/scan_capture_buffer.sv
module scan_capture_buffer
  import scb_pkg::*;
#(
  parameter int unsigned      BYTE_W   = BYTE_W_DEF,
  parameter int unsigned      SIG_W    = SIG_W_DEF,
  parameter logic [SIG_W-1:0] SIG_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tdi_bit,
  input  logic              sck_en,
  input  logic              cap_en,
  input  logic              sig_mode,
  input  logic              bit8_tick,
  input  logic              len_en,
  input  logic              len_tc,
  input  logic              rd_req,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              full,
  output logic              empty,
  output logic [SIG_W-1:0]  sig_value
);
  logic     rst_sync_n;
  logic     bit_live;
  logic     pop;
  logic     seed_we;
  logic     sig_step;
  cap_req_t cap_req;

  scb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    bit_live       = cap_en && sck_en;
    cap_req.shift  = bit_live && !sig_mode && !full;
    cap_req.bit_in = tdi_bit;
    cap_req.close  = bit8_tick || (len_en && len_tc);
    pop            = rd_req && !empty && !sig_mode;
    seed_we        = wr_req && sig_mode;
    sig_step       = bit_live && sig_mode;
  end

  scb_byte_fifo #(.BYTE_W(BYTE_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (cap_req),
    .pop   (pop),
    .head  (rd_data),
    .full  (full),
    .empty (empty)
  );

  scb_sig_compactor #(
    .BYTE_W   (BYTE_W),
    .SIG_W    (SIG_W),
    .SIG_POLY (SIG_POLY)
  ) u_sig (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .seed_we   (seed_we),
    .seed_byte (wr_data),
    .step      (sig_step),
    .bit_in    (tdi_bit),
    .sig_q     (sig_value)
  );

  // R2: with capture idle and no read, the queue outputs hold
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((!cap_en || !sck_en) && !rd_req) |=> ($stable(rd_data) && $stable(full) && $stable(empty)));
  // R8: outside compactor mode the signature never changes
  a_r8_sig_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sig_mode |=> $stable(sig_value));
  // R9: in compactor mode the queue is frozen
  a_r9_queue_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sig_mode |=> ($stable(rd_data) && $stable(full) && $stable(empty)));
endmodule

// File: tb/scan_capture_buffer_tb.sv
module scan_capture_buffer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tdi_bit, sck_en, cap_en, sig_mode, bit8_tick, len_en, len_tc;
  logic        rd_req, wr_req;
  logic [7:0]  wr_data, rd_data;
  logic        full, empty;
  logic [15:0] sig_value;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  logic [7:0]  q_m[$];
  logic [7:0]  acc_m;
  logic [15:0] sig_m;

  always #(CLK_P/2) clk = ~clk;

  scan_capture_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .tdi_bit(tdi_bit), .sck_en(sck_en), .cap_en(cap_en),
    .sig_mode(sig_mode), .bit8_tick(bit8_tick), .len_en(len_en), .len_tc(len_tc),
    .rd_req(rd_req), .rd_data(rd_data), .wr_req(wr_req), .wr_data(wr_data),
    .full(full), .empty(empty), .sig_value(sig_value)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({phase, " rd_data"}, {8'h00, rd_data}, {8'h00, (q_m.size() > 0) ? q_m[0] : 8'h00});
    chk({phase, " full"},    {15'd0, full},    {15'd0, q_m.size() == 2});
    chk({phase, " empty"},   {15'd0, empty},   {15'd0, q_m.size() == 0});
    chk({phase, " sig"},     sig_value,        sig_m);
  endtask

  // Called just after a falling edge: drive, predict, then sample at the next falling edge.
  task automatic step(input logic b, input logic cap, input logic sck, input logic sm,
                      input logic rd, input logic wr, input logic [7:0] wd,
                      input logic t8, input logic le, input logic tc);
    logic full_pre, empty_pre, fb;
    tdi_bit = b; cap_en = cap; sck_en = sck; sig_mode = sm; rd_req = rd;
    wr_req = wr; wr_data = wd; bit8_tick = t8; len_en = le; len_tc = tc;
    full_pre  = (q_m.size() == 2);
    empty_pre = (q_m.size() == 0);
    if (sm && wr) sig_m = {sig_m[7:0], wd};
    else if (sm && cap && sck) begin
      fb = sig_m[15] ^ b;
      sig_m = {sig_m[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    if (cap && sck && !sm && !full_pre) begin
      acc_m = {b, acc_m[7:1]};
      if (t8 || (le && tc)) begin
        q_m.push_back(acc_m);
        acc_m = 8'h00;
      end
    end
    if (rd && !empty_pre && !sm) void'(q_m.pop_front());
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic feed(input logic [7:0] v, input int n, input bit use_len);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) step(v[i], 1, 1, 0, 0, 0, 8'h00, !use_len, use_len, use_len);
      else            step(v[i], 1, 1, 0, 0, 0, 8'h00, 0, 0, 0);
    end
  endtask

  task automatic read1();
    step(0, 0, 0, 0, 1, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    acc_m = 8'h00; sig_m = 16'h0000;
    tdi_bit = 0; cap_en = 0; sck_en = 0; sig_mode = 0; rd_req = 0; wr_req = 0;
    wr_data = 8'h00; bit8_tick = 0; len_en = 0; len_tc = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    phase = "R1";
    chk("R1 empty", {15'd0, empty}, 16'd1);
    chk("R1 full", {15'd0, full}, 16'd0);
    chk("R1 rd_data", {8'd0, rd_data}, 16'd0);
    chk("R1 sig", sig_value, 16'd0);

    // R3 R4 full byte closed by tick
    phase = "R3";
    feed(8'h3C, 8, 0);
    chk("R3 byte order", {8'd0, rd_data}, 16'h003C);
    phase = "R7"; read1();
    chk("R7 read empties", {15'd0, empty}, 16'd1);

    // R5 short byte via length counter; tc without enable closes nothing
    phase = "R5";
    step(1, 1, 1, 0, 0, 0, 8'h00, 0, 0, 1);
    chk("R5 tc without len_en", {15'd0, empty}, 16'd1);
    read1();
    feed(8'h00, 0, 0);
    // finish that byte: 4 more bits 1,0,1,0 with last closed by length -> bits 1,1,0,1,0
    step(1, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 8'h00, 0, 1, 1);
    chk("R5 short byte", {8'd0, rd_data}, 16'h0058);
    read1();

    // R2 gated capture
    phase = "R2";
    step(1, 0, 1, 0, 0, 0, 8'h00, 1, 0, 0);
    step(1, 1, 0, 0, 0, 0, 8'h00, 1, 0, 0);
    chk("R2 no capture when gated", {15'd0, empty}, 16'd1);

    // R6 R10 fill two, overflow ignored, order kept
    phase = "R6";
    feed(8'hA1, 8, 0);
    feed(8'h07, 3, 1);
    chk("R6 full", {15'd0, full}, 16'd1);
    feed(8'hFF, 8, 0);
    chk("R6 overflow ignored", {8'd0, rd_data}, 16'h00A1);
    phase = "R10"; read1();
    chk("R10 second byte", {8'd0, rd_data}, 16'h00E0);
    // R7 read together with close of next byte
    phase = "R7";
    for (int i = 0; i < 7; i++) step(i[0], 1, 1, 0, 0, 0, 8'h00, 0, 0, 0);
    step(1, 1, 1, 0, 1, 0, 8'h00, 1, 0, 0);
    chk("R7 pop with close", {8'd0, rd_data}, 16'h00AA);
    read1(); read1();
    chk("R7 empty read ignored", {15'd0, empty}, 16'd1);

    // R8 seed writes, ignored outside compactor mode
    phase = "R8";
    step(0, 0, 0, 0, 0, 1, 8'h55, 0, 0, 0);
    chk("R8 write ignored", sig_value, 16'h0000);
    step(0, 0, 0, 1, 0, 1, 8'h12, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1, 8'h34, 0, 0, 0);
    chk("R8 seed", sig_value, 16'h1234);
    step(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, 0);

    // R9 compaction, queue frozen, read ignored
    phase = "R9";
    step(1, 1, 1, 1, 0, 0, 8'h00, 1, 0, 0);
    chk("R9 one bit from zero", sig_value, 16'h1021);
    for (int i = 0; i < 20; i++) step(i % 3 == 0, 1, 1, 1, 1, 0, 8'h00, 1, 1, 1);
    chk("R9 queue frozen", {15'd0, empty}, 16'd1);
    idle();

    // random mix against the model
    phase = "R10 random";
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(r[0], r[1] | r[2], r[3] | r[2], ($urandom % 8) == 0, r[4] & r[5],
           r[6], 8'($urandom), ($urandom % 6) == 0, r[7], r[8] & r[9]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule